// File: doc/BRIEF.md
# VRAM Rectangle Copy Unit

This block moves a rectangle of 16-bit pixels from one place to another inside a single frame memory. Frame memory is 1024 columns by 512 rows at the default parameters. It receives three 32-bit words together with a start strobe: the source corner, the destination corner and the rectangle size. It also takes a flag that forces the top pixel bit on every pixel it writes. It then runs the copy row by row, using one read port and one write port of the external frame memory. The read port returns data one cycle after the request.

Coordinates wrap at the memory edges. When a plain forward pass could read pixels that it has already overwritten, the unit stages each row through a small line buffer. The same happens when a span crosses the right edge, and when mask forcing is on. In this staged mode it reads a whole chunk before it writes any of that chunk. Otherwise it streams each pixel straight from the read port to the write port. A copy onto itself with mask forcing off is dropped without touching memory. A one-cycle done pulse marks the end of every accepted copy.

Top module: `vram_rect_copy`

## Requirements
- R1: The source and destination column comes from the low XB bits of bits 9:0 of the position word, and the row from the low YB bits of bits 24:16. All other bits are ignored. The memory address is {row, column}.
- R2: Width is ((size_word - 1) mod 2^XB) + 1 and height is ((size_word[31:16] - 1) mod 2^YB) + 1. A zero field therefore means the full memory span.
- R3: Suppose the source equals the destination in both column and row, and mask forcing is off. Then no read or write is issued, and done pulses in the cycle after the start is accepted.
- R4: Source and destination columns wrap modulo 2^XB, and rows wrap modulo 2^YB.
- R5: The staged mode is used when any of these holds: sx < dx < sx+w, sx+w > 2^XB, dx+w > 2^XB, or mask forcing is on. Each row is then split, left to right, into chunks of at most CHUNK pixels. All reads of a chunk come before any write of it.
- R6: In every other case, each row is copied pixel by pixel from left to right, and rows are copied top to bottom. A pixel written earlier in the copy is seen by a later read.
- R7: With mask forcing on, every written pixel has bit 15 set. This also applies when source and destination coincide.
- R8: Done is a single-cycle pulse, one cycle after the final destination write. Reads and writes occur only while busy.
- R9: A start while busy is ignored, including its parameter words and mask flag.
- R10: After reset, and after a reset in the middle of a copy, the unit is idle: busy, done, rd_en and wr_en are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a copy (accepted only when idle) |
| src_word | input | 32 | Source position word |
| dst_word | input | 32 | Destination position word |
| size_word | input | 32 | Width (low half) and height (high half) |
| force_mask | input | 1 | Force bit 15 on every written pixel |
| busy | output | 1 | A copy is in progress |
| done | output | 1 | One-cycle end-of-copy pulse |
| rd_en | output | 1 | Frame memory read request |
| rd_addr | output | XB+YB | Read address {row, column} |
| rd_data | input | 16 | Read data, valid the cycle after rd_en |
| wr_en | output | 1 | Frame memory write strobe |
| wr_addr | output | XB+YB | Write address {row, column} |
| wr_data | output | 16 | Write data |

## Verification
The bench builds the unit with XB=6, YB=5 and CHUNK=8. This gives a 64 by 32 memory that the bench models in full and compares after every copy. At that size, a zero size field spans the whole memory, and both column and row wraparound are reached with short rectangles. With an 8-pixel chunk, an overlapping copy that is 20 pixels wide crosses two chunk boundaries, so the chunk-ordered result differs visibly from a whole-row copy.

// File: rtl/vrc_pkg.sv
package vrc_pkg;

    localparam int PIX_W    = 16;
    localparam int X_LSB    = 0;
    localparam int Y_LSB    = 16;

    typedef logic [15:0] vrc_dim_t;

    typedef enum logic [2:0] {
        VRC_IDLE,
        VRC_STREAM,
        VRC_FILL,
        VRC_DRAIN,
        VRC_DONE
    } vrc_state_e;

    typedef struct packed {
        vrc_dim_t sx;
        vrc_dim_t sy;
        vrc_dim_t dx;
        vrc_dim_t dy;
        vrc_dim_t w;
        vrc_dim_t h;
        logic     mask;
        logic     staged;
        logic     skip;
    } vrc_job_t;

    // ((raw - 1) mod 2^bits) + 1 : a zero field means the full span
    function automatic vrc_dim_t span_decode(input logic [31:0] raw, input int bits);
        logic [31:0] lim;
        lim = (32'd1 << bits) - 32'd1;
        return vrc_dim_t'(((raw - 32'd1) & lim) + 32'd1);
    endfunction

    // length of the segment starting at column offset base
    function automatic vrc_dim_t seg_len(input vrc_dim_t w, input vrc_dim_t base,
                                         input logic staged, input int chunk);
        vrc_dim_t rem;
        rem = w - base;
        if (staged && rem > vrc_dim_t'(chunk))
            return vrc_dim_t'(chunk);
        return rem;
    endfunction

endpackage

// File: rtl/vrc_decode.sv
module vrc_decode
    import vrc_pkg::*;
#(
    parameter int XB = 10,
    parameter int YB = 9
) (
    input  logic [31:0] src_word,
    input  logic [31:0] dst_word,
    input  logic [31:0] size_word,
    input  logic        force_mask,
    output vrc_job_t    job
);
    localparam logic [16:0] COLS = 17'(1 << XB);

    logic [16:0] s_end;
    logic [16:0] d_end;
    logic        unused_bits;

    assign unused_bits = ^{src_word, dst_word};

    always_comb begin
        job.sx   = vrc_dim_t'(src_word[X_LSB +: XB]);
        job.sy   = vrc_dim_t'(src_word[Y_LSB +: YB]);
        job.dx   = vrc_dim_t'(dst_word[X_LSB +: XB]);
        job.dy   = vrc_dim_t'(dst_word[Y_LSB +: YB]);
        job.w    = span_decode(size_word, XB);
        job.h    = span_decode({16'd0, size_word[31:16]}, YB);
        job.mask = force_mask;
        s_end    = {1'b0, job.sx} + {1'b0, job.w};
        d_end    = {1'b0, job.dx} + {1'b0, job.w};
        job.staged = ((job.sx < job.dx) && ({1'b0, job.dx} < s_end))
                   || (s_end > COLS) || (d_end > COLS) || force_mask;
        job.skip = (job.sx == job.dx) && (job.sy == job.dy) && !force_mask;
    end

endmodule

// File: rtl/vrc_linebuf.sv
module vrc_linebuf #(
    parameter int DEPTH = 64,
    parameter int W     = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            store[waddr] <= wdata;
    end

    assign rdata = store[raddr];

endmodule

// File: rtl/vrc_seq.sv
module vrc_seq
    import vrc_pkg::*;
#(
    parameter int XB    = 10,
    parameter int YB    = 9,
    parameter int CHUNK = 64,
    localparam int AW   = XB + YB,
    localparam int LBW  = (CHUNK > 1) ? $clog2(CHUNK) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  vrc_job_t       job,
    output logic           busy,
    output logic           done,
    output logic           rd_en,
    output logic [AW-1:0]  rd_addr,
    output logic           wr_en,
    output logic [AW-1:0]  wr_addr,
    output logic           wr_sel,
    output logic           mask_q,
    output logic           lb_we,
    output logic [LBW-1:0] lb_waddr,
    output logic [LBW-1:0] lb_raddr
);
    vrc_state_e st;
    vrc_job_t   job_q;
    vrc_dim_t   row, base, slen, idx, pend_i;
    logic       pend_v;

    vrc_dim_t   next_base;
    vrc_dim_t   wr_off;
    logic       last_write;
    logic       seg_more;
    logic       row_more;
    logic [XB-1:0] rd_col, wr_col;
    logic [YB-1:0] rd_row, wr_row;
    logic       unused_q;

    assign unused_q = job_q.skip;

    always_comb begin
        busy  = (st != VRC_IDLE);
        done  = (st == VRC_DONE);
        rd_en = 1'b0;
        wr_en = 1'b0;
        lb_we = 1'b0;
        unique case (st)
            VRC_STREAM: begin
                rd_en = (idx < slen);
                wr_en = pend_v;
            end
            VRC_FILL: begin
                rd_en = (idx < slen);
                lb_we = pend_v;
            end
            VRC_DRAIN: wr_en = 1'b1;
            default: ;
        endcase
    end

    always_comb begin
        wr_off     = (st == VRC_DRAIN) ? idx : pend_i;
        rd_col     = XB'(job_q.sx + base + idx);
        wr_col     = XB'(job_q.dx + base + wr_off);
        rd_row     = YB'(job_q.sy + row);
        wr_row     = YB'(job_q.dy + row);
        next_base  = base + slen;
        seg_more   = (next_base < job_q.w);
        row_more   = ((row + 16'd1) < job_q.h);
        last_write = ((st == VRC_STREAM) && (idx == slen))
                  || ((st == VRC_DRAIN) && (idx == slen - 16'd1));
    end

    assign rd_addr  = {rd_row, rd_col};
    assign wr_addr  = {wr_row, wr_col};
    assign wr_sel   = (st == VRC_DRAIN);
    assign mask_q   = job_q.mask;
    assign lb_waddr = pend_i[LBW-1:0];
    assign lb_raddr = idx[LBW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= VRC_IDLE;
            job_q  <= '0;
            row    <= '0;
            base   <= '0;
            slen   <= '0;
            idx    <= '0;
            pend_v <= 1'b0;
            pend_i <= '0;
        end else begin
            pend_v <= rd_en;
            pend_i <= idx;
            unique case (st)
                VRC_IDLE: begin
                    if (start) begin
                        job_q <= job;
                        row   <= '0;
                        base  <= '0;
                        idx   <= '0;
                        slen  <= seg_len(job.w, '0, job.staged, CHUNK);
                        if (job.skip)
                            st <= VRC_DONE;
                        else if (job.staged)
                            st <= VRC_FILL;
                        else
                            st <= VRC_STREAM;
                    end
                end
                VRC_FILL: begin
                    if (idx == slen) begin
                        st  <= VRC_DRAIN;
                        idx <= '0;
                    end else begin
                        idx <= idx + 16'd1;
                    end
                end
                VRC_STREAM, VRC_DRAIN: begin
                    if (last_write) begin
                        idx <= '0;
                        if (seg_more) begin
                            base <= next_base;
                            slen <= seg_len(job_q.w, next_base, job_q.staged, CHUNK);
                            st   <= job_q.staged ? VRC_FILL : VRC_STREAM;
                        end else if (row_more) begin
                            row  <= row + 16'd1;
                            base <= '0;
                            slen <= seg_len(job_q.w, '0, job_q.staged, CHUNK);
                            st   <= job_q.staged ? VRC_FILL : VRC_STREAM;
                        end else begin
                            st <= VRC_DONE;
                        end
                    end else begin
                        idx <= idx + 16'd1;
                    end
                end
                VRC_DONE: st <= VRC_IDLE;
                default:  st <= VRC_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/vram_rect_copy.sv
module vram_rect_copy
    import vrc_pkg::*;
#(
    parameter int XB    = 10,
    parameter int YB    = 9,
    parameter int CHUNK = 64,
    localparam int AW   = XB + YB,
    localparam int LBW  = (CHUNK > 1) ? $clog2(CHUNK) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [31:0]       src_word,
    input  logic [31:0]       dst_word,
    input  logic [31:0]       size_word,
    input  logic              force_mask,
    output logic              busy,
    output logic              done,
    output logic              rd_en,
    output logic [AW-1:0]     rd_addr,
    input  logic [PIX_W-1:0]  rd_data,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [PIX_W-1:0]  wr_data
);
    vrc_job_t         job;
    logic             wr_sel;
    logic             mask_q;
    logic             lb_we;
    logic [LBW-1:0]   lb_waddr;
    logic [LBW-1:0]   lb_raddr;
    logic [PIX_W-1:0] lb_rdata;

    vrc_decode #(.XB(XB), .YB(YB)) u_decode (
        .src_word   (src_word),
        .dst_word   (dst_word),
        .size_word  (size_word),
        .force_mask (force_mask),
        .job        (job)
    );

    vrc_seq #(.XB(XB), .YB(YB), .CHUNK(CHUNK)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .job      (job),
        .busy     (busy),
        .done     (done),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_sel   (wr_sel),
        .mask_q   (mask_q),
        .lb_we    (lb_we),
        .lb_waddr (lb_waddr),
        .lb_raddr (lb_raddr)
    );

    vrc_linebuf #(.DEPTH(CHUNK), .W(PIX_W)) u_linebuf (
        .clk   (clk),
        .we    (lb_we),
        .waddr (lb_waddr),
        .wdata (rd_data),
        .raddr (lb_raddr),
        .rdata (lb_rdata)
    );

    assign wr_data = (wr_sel ? lb_rdata : rd_data) | {mask_q, {(PIX_W-1){1'b0}}};

endmodule

// File: rtl/vram_rect_copy_chk.sv
module vram_rect_copy_chk #(
    parameter int XB = 10,
    parameter int YB = 9
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          force_mask,
    input logic [XB-1:0] src_x,
    input logic [YB-1:0] src_y,
    input logic [XB-1:0] dst_x,
    input logic [YB-1:0] dst_y,
    input logic          busy,
    input logic          done,
    input logic          rd_en,
    input logic          wr_en,
    input logic          wr_msb
);
    logic mask_l;
    logic skip_l;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_l <= 1'b0;
            skip_l <= 1'b0;
        end else if (start && !busy) begin
            mask_l <= force_mask;
            skip_l <= (src_x == dst_x) && (src_y == dst_y) && !force_mask;
        end
    end

    assert_reset_idle_R10: assert property (@(posedge clk)
        rst |=> (!busy && !done && !rd_en && !wr_en));

    assert_accept_R9: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    assert_skip_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && skip_l) |-> (!rd_en && !wr_en));

    assert_mask_set_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && mask_l) |-> wr_msb);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_write_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(wr_en) || skip_l));

    assert_access_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_en || wr_en) |-> busy);

endmodule

bind vram_rect_copy vram_rect_copy_chk #(.XB(XB), .YB(YB)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .force_mask (force_mask),
    .src_x      (src_word[XB-1:0]),
    .src_y      (src_word[16 +: YB]),
    .dst_x      (dst_word[XB-1:0]),
    .dst_y      (dst_word[16 +: YB]),
    .busy       (busy),
    .done       (done),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .wr_msb     (wr_data[15])
);

// File: tb/vram_rect_copy_tb.sv
module vram_rect_copy_tb;
    localparam int XB    = 6;
    localparam int YB    = 5;
    localparam int CHUNK = 8;
    localparam int AW    = XB + YB;
    localparam int COLS  = 1 << XB;
    localparam int ROWS  = 1 << YB;
    localparam int NPIX  = COLS * ROWS;

    typedef struct packed {
        logic [31:0] s;
        logic [31:0] d;
        logic [31:0] z;
        logic        m;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{32'h0001_0002, 32'h000A_001E, 32'h0003_0005, 1'b0}, // 0  R6 plain
        '{32'h0004_000A, 32'h0004_0006, 32'h0002_000C, 1'b0}, // 1  R6 dx<sx overlap
        '{32'h0008_0004, 32'h0008_0007, 32'h0002_0006, 1'b0}, // 2  R5 short overlap
        '{32'h000C_0000, 32'h000C_0003, 32'h0001_0014, 1'b0}, // 3  R5 chunked overlap
        '{32'h0002_003C, 32'h0003_000A, 32'h0002_0008, 1'b0}, // 4  R4 column wrap
        '{32'h001E_0005, 32'h001D_003E, 32'h0004_0004, 1'b0}, // 5  R4 row wrap
        '{32'h0006_0001, 32'h0014_0028, 32'h0002_0009, 1'b1}, // 6  R7 mask
        '{32'hFE35_FC43, 32'h80E2_7C10, 32'h0002_0003, 1'b0}, // 7  R1 stray bits
        '{32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 1'b1}, // 8  R2 zero size
        '{32'h0003_0004, 32'h0009_0010, 32'h0021_0041, 1'b0}, // 9  R2 modulo size
        '{32'h0007_0011, 32'h0007_0011, 32'h0005_0005, 1'b0}, // 10 R3 skip
        '{32'h0007_0011, 32'h0007_0011, 32'h0002_0004, 1'b1}  // 11 R7 in place
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [31:0]   src_w = '0, dst_w = '0, size_w = '0;
    logic          fmask = 1'b0;
    logic          busy, done, rd_en, wr_en;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [15:0]   rd_data, wr_data;

    logic          fill_go = 1'b0;
    int            fill_seed = 0;
    logic [15:0]   mem [NPIX];
    logic [15:0]   expv [NPIX];

    int n_chk = 0, n_fail = 0;
    int cyc = 0, last_wr = -1, done_cyc = -1, acc_cyc = -1;
    int acc_cnt = 0, done_cnt = 0;

    always #10 clk = ~clk;

    vram_rect_copy #(.XB(XB), .YB(YB), .CHUNK(CHUNK)) u_dut (
        .clk(clk), .rst(rst), .start(start),
        .src_word(src_w), .dst_word(dst_w), .size_word(size_w),
        .force_mask(fmask), .busy(busy), .done(done),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    function automatic logic [15:0] pat(input int i, input int seed);
        return 16'((i * 73) + (seed * 911) + (i >> 4));
    endfunction

    // frame memory model: one read port (1-cycle latency), one write port
    always @(posedge clk) begin
        if (fill_go) begin
            for (int i = 0; i < NPIX; i++) mem[i] <= pat(i, fill_seed);
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
        rd_data <= mem[rd_addr];
    end

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (wr_en) last_wr <= cyc;
        if (rd_en || wr_en) acc_cnt <= acc_cnt + 1;
        if (start && !busy && !rst) acc_cyc <= cyc;
        if (done) begin
            done_cnt <= done_cnt + 1;
            done_cyc <= cyc;
        end
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got cycle %0d expected under 150000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    function automatic string req_of(input int i);
        case (i)
            0, 1:    return "R6";
            2, 3:    return "R5";
            4, 5:    return "R4";
            6, 11:   return "R7";
            7:       return "R1";
            8, 9:    return "R2";
            default: return "R3";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp_v);
        end
    endtask

    task automatic fill(input int seed);
        @(posedge clk); #2;
        fill_seed = seed;
        fill_go = 1'b1;
        @(posedge clk); #2;
        fill_go = 1'b0;
        for (int i = 0; i < NPIX; i++) expv[i] = pat(i, seed);
    endtask

    // reference copy built from the requirements
    task automatic ref_copy(input vec_t v);
        int sx, sy, dx, dy, w, h;
        bit stg;
        logic [15:0] mb;
        logic [15:0] tmp [CHUNK];
        sx = int'(v.s[5:0]);  sy = int'(v.s[20:16]);
        dx = int'(v.d[5:0]);  dy = int'(v.d[20:16]);
        w  = int'((v.z - 32'd1) & 32'd63) + 1;
        h  = int'(({16'd0, v.z[31:16]} - 32'd1) & 32'd31) + 1;
        if (sx == dx && sy == dy && !v.m) return;
        stg = (sx < dx && dx < sx + w) || (sx + w > COLS) || (dx + w > COLS) || v.m;
        mb  = v.m ? 16'h8000 : 16'h0000;
        for (int r = 0; r < h; r++) begin
            int ys, yd;
            ys = (sy + r) % ROWS;
            yd = (dy + r) % ROWS;
            if (stg) begin
                for (int b = 0; b < w; b += CHUNK) begin
                    int n;
                    n = (w - b > CHUNK) ? CHUNK : w - b;
                    for (int k = 0; k < n; k++)
                        tmp[k] = expv[ys * COLS + (sx + b + k) % COLS];
                    for (int k = 0; k < n; k++)
                        expv[yd * COLS + (dx + b + k) % COLS] = tmp[k] | mb;
                end
            end else begin
                for (int k = 0; k < w; k++)
                    expv[yd * COLS + (dx + k) % COLS] = expv[ys * COLS + (sx + k) % COLS];
            end
        end
    endtask

    task automatic compare(input string req, input string what);
        int bad, first;
        bad = 0; first = -1;
        for (int i = 0; i < NPIX; i++) begin
            if (mem[i] !== expv[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        end
        if (bad == 0) chk(1'b1, req, what, 0, 0);
        else chk(1'b0, req, what, longint'(mem[first]), longint'(expv[first]));
    endtask

    task automatic kick(input vec_t v);
        @(posedge clk); #2;
        src_w = v.s; dst_w = v.d; size_w = v.z; fmask = v.m;
        start = 1'b1;
        @(posedge clk); #2;
        start = 1'b0;
    endtask

    task automatic wait_done(input int d0);
        int k;
        k = 0;
        while (done_cnt == d0 && k < 20000) begin
            @(negedge clk);
            k++;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk); #1;
        // R10 reset state
        chk(busy == 1'b0,  "R10", "busy after reset", busy, 0);
        chk(done == 1'b0,  "R10", "done after reset", done, 0);
        chk(rd_en == 1'b0, "R10", "rd_en after reset", rd_en, 0);
        chk(wr_en == 1'b0, "R10", "wr_en after reset", wr_en, 0);

        for (int i = 0; i < 12; i++) begin
            int d0, a0;
            fill(i + 1);
            d0 = done_cnt;
            a0 = acc_cnt;
            kick(VECS[i]);
            wait_done(d0);
            ref_copy(VECS[i]);
            compare(req_of(i), $sformatf("memory after vector %0d", i));
            chk(done_cnt == d0 + 1, "R8", $sformatf("done pulses vector %0d", i),
                done_cnt - d0, 1);
            if (i == 10) begin
                // R3 no access, done the cycle after acceptance
                chk(acc_cnt == a0, "R3", "accesses on skipped copy", acc_cnt - a0, 0);
                chk(done_cyc == acc_cyc + 1, "R3", "skip done cycle", done_cyc, acc_cyc + 1);
            end else begin
                chk(done_cyc == last_wr + 1, "R8", $sformatf("done timing vector %0d", i),
                    done_cyc, last_wr + 1);
            end
        end

        // R9 start while busy is ignored
        begin
            int d0;
            fill(40);
            d0 = done_cnt;
            kick(VECS[0]);
            repeat (3) @(posedge clk);
            kick(VECS[6]);
            wait_done(d0);
            repeat (30) @(negedge clk);
            ref_copy(VECS[0]);
            compare("R9", "memory after start while busy");
            chk(done_cnt == d0 + 1, "R9", "done pulses with ignored start", done_cnt - d0, 1);
        end

        // R10 reset in the middle of a copy
        begin
            int a0;
            fill(50);
            kick(VECS[8]);
            repeat (40) @(posedge clk);
            #2 rst = 1'b1;
            repeat (2) @(posedge clk);
            #2 rst = 1'b0;
            @(negedge clk); #1;
            chk(busy == 1'b0 && done == 1'b0, "R10", "busy/done after mid-copy reset",
                {busy, done}, 0);
            a0 = acc_cnt;
            repeat (20) @(negedge clk);
            chk(acc_cnt == a0, "R10", "accesses after mid-copy reset", acc_cnt - a0, 0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule